// File: doc/BRIEF.md
# Wait-State Bus Cycle Sequencer

This block runs read and write cycles on an external 16-bit bus as its master. A host hands it one request at a time over a level request / one-cycle acknowledge handshake. The block then asserts a read or write strobe, drives the address and an active-low window select, and places write data on the data port. Each cycle lasts a programmed number of wait states, from 0 to 7. When ready checking is turned on, the cycle is also stretched until an active-low ready line, passed through a two-stage synchronizer, is seen low. The ready line is not looked at before the wait states run out. Because of this, a peripheral that holds ready low while idle cannot end a cycle before it has had time to respond.

A single configuration word holds four things: ready checking, the wait count, the master/slave mode and a run bit. Writing the run bit as 0 puts the whole sequencer back into its power-up state at once. A separate status word reflects a hold-mode input and two interrupt inputs. After reset the block is a slave. Its strobes are not driven and requests are ignored until software selects master mode.

Top module: `wsbus_ctrl`

## Requirements
- R1: After hardware reset, `cfg_q` reads 0x20: run bit 5 = 1, master bit 4 = 0, wait field bits 3:1 = 0, ready-enable bit 0 = 0. In this state the strobes and select are high (inactive), and `bus_cmd_oe`, `bus_d_oe` and `ack` are low.
- R2: While the master bit is 0, a request is ignored. No strobe or select goes low and `ack` stays low.
- R3: With ready-enable 0, the strobe stays low for exactly W+1 clocks, where W is the wait count. `bus_rdy_n` has no effect.
- R4: With ready-enable 1, the cycle ends on the first clock edge that satisfies both of these: at least W+1 edges have passed since the strobe fell, and the synchronized ready is low. The synchronized ready seen at an edge is the pin value captured two edges earlier.
- R5: The wait count and ready-enable are latched when a cycle starts. A configuration write during the cycle does not change that cycle's length.
- R6: `ack` is high for exactly one clock, the clock right after the strobe rises. For reads, `rd_data` holds the value of `bus_d_in` captured on the edge that ends the cycle.
- R7: For a write, `bus_d_out` carries the request data and `bus_d_oe` is high from the clock the strobe falls through one clock after the strobe rises. For a read, and while idle, `bus_d_oe` is low.
- R8: Between the strobe rising and the next strobe falling, at least 3 clocks pass. A ready release caused by the trailing strobe edge therefore cannot end the next cycle.
- R9: Writing the configuration with bit 5 = 0 aborts any cycle on the same edge, with no `ack`. `cfg_q` then reads 0x00, and the other bits of that write are discarded. Writing bit 5 = 1 loads all fields and resumes operation.
- R10: `stat_q` = {irq2, irq1, hold}. It follows `irq2_in`, `irq1_in` and `hold_in` one clock later.
- R11: `bus_cmd_oe` equals the master bit. `bus_sel_n` is low exactly while one strobe is low, and never both strobes at once. `bus_addr` holds the request address, unchanged, for the whole strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_q | output | 8 | Configuration readback |
| stat_q | output | 3 | Status {irq2, irq1, hold} |
| req | input | 1 | Cycle request, held until ack |
| req_we | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-clock cycle-complete pulse |
| rd_data | output | 16 | Captured read data |
| bus_cmd_oe | output | 1 | Strobes are driven (master mode) |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_sel_n | output | 1 | Window select, active low |
| bus_addr | output | 16 | Bus address |
| bus_d_out | output | 16 | Data port output value |
| bus_d_oe | output | 1 | Data port drive enable (0 = high impedance) |
| bus_d_in | input | 16 | Data port input value |
| bus_rdy_n | input | 1 | Asynchronous ready, active low |
| hold_in | input | 1 | Hold-mode indication |
| irq1_in | input | 1 | Interrupt line 1 |
| irq2_in | input | 1 | Interrupt line 2 |

## Verification
The end of the wait count and the sampling of ready can fall on the same edge. A peripheral that idles with ready low is used to provoke this. It raises ready on the strobe fall and lowers it again after a set delay, and the bench checks runs with the delay both before and after the last wait state. Each run is judged by comparing the measured strobe length against max(W+1, delay+2). Back-to-back cycles are also issued against a device that releases ready on the trailing strobe edge. Here the next cycle must still last the full synchronized delay, which shows that the release cannot leak into the following cycle.

// File: rtl/wsbus_pkg.sv
`timescale 1ns/1ps
// Shared types and configuration field positions for the wait-state bus sequencer.
// Assumes an 8-bit configuration word; positions below are what the host software decodes.
package wsbus_pkg;
    localparam int CFG_W          = 8;
    localparam int WS_W           = 3;
    localparam int CFG_BIT_RDY    = 0;
    localparam int CFG_LSB_WAIT   = 1;
    localparam int CFG_BIT_MASTER = 4;
    localparam int CFG_BIT_RUN    = 5;
    localparam int STAT_W         = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic            run;
        logic            master;
        logic [WS_W-1:0] waits;
        logic            rdy_en;
    } cfg_t;
endpackage

// File: rtl/wsbus_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for one asynchronous input bit.
// Assumes STAGES >= 2; resets every stage to RESET_VAL.
module wsbus_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[gi] <= RESET_VAL;
                else if (gi == 0)
                    chain[gi] <= d;
                else
                    chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wsbus_regs.sv
`timescale 1ns/1ps
// Configuration and status registers.
// A write with the run bit clear empties the configuration (soft reset); a write
// with it set loads every field. Status is a one-clock registered copy of the inputs.
module wsbus_regs
    import wsbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output cfg_t              cfg,
    output logic [CFG_W-1:0]  cfg_q,
    input  logic              hold_in,
    input  logic              irq1_in,
    input  logic              irq2_in,
    output logic [STAT_W-1:0] stat_q
);
    localparam cfg_t CFG_RESET = '{run: 1'b1, master: 1'b0, waits: '0, rdy_en: 1'b0};

    cfg_t cfg_r;

    // Load or clear the configuration word on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_r <= CFG_RESET;
        else if (cfg_we) begin
            if (cfg_wdata[CFG_BIT_RUN])
                cfg_r <= '{run:    1'b1,
                           master: cfg_wdata[CFG_BIT_MASTER],
                           waits:  cfg_wdata[CFG_LSB_WAIT +: WS_W],
                           rdy_en: cfg_wdata[CFG_BIT_RDY]};
            else
                cfg_r <= '0;
        end
    end

    // Register the hold and interrupt inputs for the status word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= {irq2_in, irq1_in, hold_in};
    end

    // Place configuration fields at their readback positions.
    always_comb begin
        cfg_q                             = '0;
        cfg_q[CFG_BIT_RDY]                = cfg_r.rdy_en;
        cfg_q[CFG_LSB_WAIT +: WS_W]       = cfg_r.waits;
        cfg_q[CFG_BIT_MASTER]             = cfg_r.master;
        cfg_q[CFG_BIT_RUN]                = cfg_r.run;
    end

    assign cfg = cfg_r;
endmodule

// File: rtl/wsbus_seq.sv
`timescale 1ns/1ps
// Bus cycle sequencer: idle -> command (wait states, then ready) -> recovery gap.
// Assumes rdy_sync_n is already synchronized; GAP_CYC recovery clocks keep a ready
// release on the trailing strobe edge out of the next cycle.
module wsbus_seq
    import wsbus_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 16,
    parameter int GAP_CYC = 2
) (
    input  logic            clk,
    input  logic            srst_n,
    input  logic            master,
    input  logic            rdy_en,
    input  logic [WS_W-1:0] waits,
    input  logic            req,
    input  logic            req_we,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic            rdy_sync_n,
    input  logic [DW-1:0]   bus_d_in,
    output logic            ack,
    output logic [DW-1:0]   rd_data,
    output logic            bus_rd_n,
    output logic            bus_wr_n,
    output logic            bus_sel_n,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_d_out,
    output logic            bus_d_oe
);
    localparam int GCW = $clog2(GAP_CYC + 1);

    seq_state_t      state;
    logic [WS_W-1:0] wcnt;
    logic [GCW-1:0]  gcnt;
    logic            we_q;
    logic            rdy_en_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic [DW-1:0]   rdata_q;
    logic            oe_q;
    logic            ack_q;
    logic            cmd_done;

    // The cycle ends once waits are spent and, if enabled, ready is low.
    assign cmd_done = (wcnt == '0) && (!rdy_en_q || !rdy_sync_n);

    // Step the cycle state and its wait / recovery counters.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            state    <= ST_IDLE;
            wcnt     <= '0;
            gcnt     <= '0;
            we_q     <= 1'b0;
            rdy_en_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            oe_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req && master) begin
                    state    <= ST_CMD;
                    wcnt     <= waits;
                    rdy_en_q <= rdy_en;
                    we_q     <= req_we;
                    addr_q   <= req_addr;
                    wdata_q  <= req_wdata;
                    oe_q     <= req_we;
                end
                ST_CMD: begin
                    if (wcnt != '0)
                        wcnt <= wcnt - 1'b1;
                    else if (cmd_done) begin
                        state <= ST_GAP;
                        gcnt  <= GCW'(GAP_CYC - 1);
                    end
                end
                ST_GAP: begin
                    oe_q <= 1'b0;
                    if (gcnt == '0)
                        state <= ST_IDLE;
                    else
                        gcnt <= gcnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Pulse ack and capture read data on the completing edge.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= (state == ST_CMD) && cmd_done;
            if ((state == ST_CMD) && cmd_done && !we_q)
                rdata_q <= bus_d_in;
        end
    end

    assign bus_rd_n  = !((state == ST_CMD) && !we_q);
    assign bus_wr_n  = !((state == ST_CMD) &&  we_q);
    assign bus_sel_n = (state != ST_CMD);
    assign bus_addr  = addr_q;
    assign bus_d_out = wdata_q;
    assign bus_d_oe  = oe_q;
    assign ack       = ack_q;
    assign rd_data   = rdata_q;
endmodule

// File: rtl/wsbus_ctrl.sv
`timescale 1ns/1ps
// Top of the wait-state bus controller: registers, ready synchronizer and sequencer.
// Assumes the host holds req until ack; a run-bit-clear write resets everything but
// the status word on the same edge it is written.
module wsbus_ctrl
    import wsbus_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [STAT_W-1:0] stat_q,
    input  logic              req,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              ack,
    output logic [DW-1:0]     rd_data,
    output logic              bus_cmd_oe,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_sel_n,
    output logic [AW-1:0]     bus_addr,
    output logic [DW-1:0]     bus_d_out,
    output logic              bus_d_oe,
    input  logic [DW-1:0]     bus_d_in,
    input  logic              bus_rdy_n,
    input  logic              hold_in,
    input  logic              irq1_in,
    input  logic              irq2_in
);
    cfg_t cfg;
    logic soft_clr;
    logic srst_n;
    logic rdy_sync_n;

    wsbus_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .cfg_q     (cfg_q),
        .hold_in   (hold_in),
        .irq1_in   (irq1_in),
        .irq2_in   (irq2_in),
        .stat_q    (stat_q)
    );

    // Soft reset takes effect on the very edge that writes the run bit low.
    assign soft_clr = cfg_we && !cfg_wdata[CFG_BIT_RUN];
    assign srst_n   = rst_n && cfg.run && !soft_clr;

    wsbus_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_rdy_sync (
        .clk   (clk),
        .rst_n (srst_n),
        .d     (bus_rdy_n),
        .q     (rdy_sync_n)
    );

    wsbus_seq #(
        .DW      (DW),
        .AW      (AW),
        .GAP_CYC (SYNC_STAGES)
    ) u_seq (
        .clk        (clk),
        .srst_n     (srst_n),
        .master     (cfg.master),
        .rdy_en     (cfg.rdy_en),
        .waits      (cfg.waits),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rdy_sync_n (rdy_sync_n),
        .bus_d_in   (bus_d_in),
        .ack        (ack),
        .rd_data    (rd_data),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_sel_n  (bus_sel_n),
        .bus_addr   (bus_addr),
        .bus_d_out  (bus_d_out),
        .bus_d_oe   (bus_d_oe)
    );

    assign bus_cmd_oe = cfg.master;
endmodule

// File: rtl/wsbus_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for wsbus_ctrl, attached by bind; observes ports only.
module wsbus_ctrl_chk #(
    parameter int DW = 16,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [7:0]    cfg_wdata,
    input logic [7:0]    cfg_q,
    input logic [2:0]    stat_q,
    input logic          ack,
    input logic          bus_cmd_oe,
    input logic          bus_rd_n,
    input logic          bus_wr_n,
    input logic          bus_sel_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_d_oe,
    input logic          hold_in,
    input logic          irq1_in,
    input logic          irq2_in
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!bus_rd_n && !bus_wr_n)); // R11
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!bus_sel_n && $past(!bus_sel_n)) |-> $stable(bus_addr)); // R11
    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!bus_cmd_oe && bus_sel_n) |=> bus_sel_n); // R2
    AST_ACK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) ack |-> $rose(bus_sel_n)); // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R6
    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (bus_sel_n && $past(bus_sel_n)) |-> !bus_d_oe); // R7
    AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_sel_n) |=> bus_sel_n ##1 bus_sel_n); // R8
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n) (cfg_we && !cfg_wdata[5]) |=> (bus_sel_n && cfg_q == 8'h00)); // R9
    AST_STATUS_TRACK: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (stat_q == $past({irq2_in, irq1_in, hold_in}))); // R10
endmodule

bind wsbus_ctrl wsbus_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_q      (cfg_q),
    .stat_q     (stat_q),
    .ack        (ack),
    .bus_cmd_oe (bus_cmd_oe),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_sel_n  (bus_sel_n),
    .bus_addr   (bus_addr),
    .bus_d_oe   (bus_d_oe),
    .hold_in    (hold_in),
    .irq1_in    (irq1_in),
    .irq2_in    (irq2_in)
);

// File: tb/wsbus_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: bus_op pushes expected cycles, the monitor pops them on ack.
module wsbus_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_q;
    logic [2:0]  stat_q;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rd_data;
    logic        bus_cmd_oe, bus_rd_n, bus_wr_n, bus_sel_n, bus_d_oe;
    logic [15:0] bus_addr, bus_d_out, bus_d_in;
    logic        bus_rdy_n = 1'b1;
    logic        hold_in = 1'b0, irq1_in = 1'b0, irq2_in = 1'b0;

    always #4 clk = ~clk;

    wsbus_ctrl u_wsbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
        .stat_q(stat_q), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data), .bus_cmd_oe(bus_cmd_oe),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_sel_n(bus_sel_n),
        .bus_addr(bus_addr), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe),
        .bus_d_in(bus_d_in), .bus_rdy_n(bus_rdy_n), .hold_in(hold_in),
        .irq1_in(irq1_in), .irq2_in(irq2_in)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] cfgword(input logic rdy, input int w);
        return 8'h30 | 8'((w & 7) << 1) | {7'd0, rdy};
    endfunction

    // Device model: read data from address; ready high during the first dev_delay strobe clocks.
    int   dev_delay  = 0;
    logic dev_idle_n = 1'b1;
    int   dcnt       = 0;
    assign bus_d_in = bus_addr ^ 16'h5A3C;
    always @(negedge clk) begin
        if (!bus_sel_n) begin
            dcnt++;
            bus_rdy_n = (dcnt < dev_delay);
        end else begin
            dcnt = 0;
            bus_rdy_n = dev_idle_n;
        end
    end

    typedef struct packed {
        logic        we;
        logic        rdy;
        logic [15:0] addr;
        logic [15:0] data;
        logic [7:0]  len;
    } exp_t;
    exp_t expq[$];
    exp_t cur;

    task automatic bus_op(input logic we, input logic [15:0] a, input logic [15:0] d,
                          input int len, input logic rdy);
        exp_t e;
        e.we = we; e.rdy = rdy; e.addr = a; e.data = d; e.len = 8'(len);
        expq.push_back(e);
        req_we = we; req_addr = a; req_wdata = d; req = 1'b1;
        do @(negedge clk); while (!ack);
        req = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_wdata = v;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Monitor: measure strobe length and idle gap, check data/address, pop on ack.
    int   lowcnt = 0, highcnt = 100, lastlen = 0;
    logic prev_sel = 1'b1;
    bit   wr_ok = 1, addr_ok = 1, oe_chk = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_sel_n) begin
                if (prev_sel) begin
                    check(highcnt >= 3, "R8", "idle clocks between cycles", highcnt, 3);
                    lowcnt = 0; wr_ok = 1; addr_ok = 1;
                end
                lowcnt++;
                if (expq.size() > 0) begin
                    if (bus_addr != expq[0].addr) addr_ok = 0;
                    if (expq[0].we) begin
                        if (!bus_d_oe || bus_d_out != expq[0].data) wr_ok = 0;
                    end else if (bus_d_oe) wr_ok = 0;
                end
            end else begin
                if (!prev_sel) begin
                    lastlen = lowcnt;
                    highcnt = 0;
                end
                highcnt++;
            end
            if (oe_chk) begin
                check(!bus_d_oe, "R7", "data drive released", int'(bus_d_oe), 0);
                oe_chk = 0;
            end
            if (ack) begin
                if (expq.size() == 0)
                    check(0, "R6", "unexpected ack", 1, 0);
                else begin
                    cur = expq.pop_front();
                    check(lastlen == int'(cur.len), cur.rdy ? "R4" : "R3", "strobe clocks",
                          lastlen, int'(cur.len));
                    check(addr_ok, "R11", "address held", int'(addr_ok), 1);
                    if (cur.we) begin
                        check(wr_ok, "R7", "write data driven", int'(wr_ok), 1);
                        check(bus_d_oe, "R7", "drive one clock after strobe", int'(bus_d_oe), 1);
                        oe_chk = 1;
                    end else begin
                        check(wr_ok, "R7", "no drive on read", int'(wr_ok), 1);
                        check(rd_data == (cur.addr ^ 16'h5A3C), "R6", "read data",
                              int'(rd_data), int'(cur.addr ^ 16'h5A3C));
                    end
                end
            end
            prev_sel = bus_sel_n;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(cfg_q == 8'h20, "R1", "cfg after reset", int'(cfg_q), 8'h20);
        check(bus_rd_n && bus_wr_n && bus_sel_n, "R1", "strobes idle",
              int'({bus_rd_n, bus_wr_n, bus_sel_n}), 7);
        check(!bus_cmd_oe && !bus_d_oe && !ack, "R1", "enables low",
              int'({bus_cmd_oe, bus_d_oe, ack}), 0);

        // R2: slave mode ignores requests
        req = 1'b1; req_we = 1'b0; req_addr = 16'h0042;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(bus_sel_n && !ack, "R2", "request in slave mode",
                  int'({bus_sel_n, ack}), 2);
        end
        req = 1'b0;

        // R11 / R3: master, ready off, no wait states
        cfg_write(cfgword(0, 0));
        check(cfg_q == 8'h30, "R11", "cfg readback", int'(cfg_q), 8'h30);
        check(bus_cmd_oe, "R11", "strobes driven in master mode", int'(bus_cmd_oe), 1);
        dev_idle_n = 1'b1; dev_delay = 20;
        bus_op(1'b1, 16'h1234, 16'hBEEF, 1, 1'b0);
        bus_op(1'b0, 16'h00F0, 16'h0000, 1, 1'b0);

        // R3: ready ignored while disabled, maximum and middle wait counts
        cfg_write(cfgword(0, 7));
        bus_op(1'b0, 16'h0101, 16'h0000, 8, 1'b0);
        bus_op(1'b1, 16'h0202, 16'hA5A5, 8, 1'b0);
        cfg_write(cfgword(0, 3));
        bus_op(1'b0, 16'h0303, 16'h0000, 4, 1'b0);

        // R4: normally-ready device, ready sampled only after waits
        dev_idle_n = 1'b0;
        cfg_write(cfgword(1, 2)); dev_delay = 5;
        bus_op(1'b0, 16'h0404, 16'h0000, 7, 1'b1);
        cfg_write(cfgword(1, 5)); dev_delay = 1;
        bus_op(1'b1, 16'h0505, 16'h1111, 6, 1'b1);
        cfg_write(cfgword(1, 3)); dev_delay = 3;
        bus_op(1'b0, 16'h0606, 16'h0000, 5, 1'b1);
        cfg_write(cfgword(1, 7)); dev_delay = 0;
        bus_op(1'b0, 16'h0707, 16'h0000, 8, 1'b1);

        // R8: ready released on trailing edge, back-to-back cycles
        dev_idle_n = 1'b1;
        cfg_write(cfgword(1, 0)); dev_delay = 1;
        bus_op(1'b0, 16'h0808, 16'h0000, 3, 1'b1);
        bus_op(1'b1, 16'h0909, 16'h2222, 3, 1'b1);
        bus_op(1'b0, 16'h0A0A, 16'h0000, 3, 1'b1);

        // R5: configuration write mid-cycle does not alter the running cycle
        cfg_write(cfgword(0, 6));
        fork
            bus_op(1'b0, 16'h0B0B, 16'h0000, 7, 1'b0);
            begin
                repeat (3) @(negedge clk);
                cfg_write(cfgword(0, 0));
            end
        join
        check(cfg_q == 8'h30, "R5", "new cfg visible", int'(cfg_q), 8'h30);
        bus_op(1'b1, 16'h0C0C, 16'h3333, 1, 1'b0);

        // R10: status follows inputs one clock later
        hold_in = 1'b1; irq1_in = 1'b0; irq2_in = 1'b1;
        @(negedge clk);
        check(stat_q == 3'b101, "R10", "status pattern A", int'(stat_q), 5);
        hold_in = 1'b0; irq1_in = 1'b1; irq2_in = 1'b0;
        @(negedge clk);
        check(stat_q == 3'b010, "R10", "status pattern B", int'(stat_q), 2);

        // R9: soft reset aborts a cycle and clears configuration
        cfg_write(cfgword(0, 7));
        req = 1'b1; req_we = 1'b0; req_addr = 16'h0D0D;
        repeat (3) @(negedge clk);
        check(!bus_sel_n, "R9", "cycle in progress", int'(bus_sel_n), 0);
        cfg_write(8'h1E);
        check(bus_sel_n && !ack, "R9", "aborted on write edge", int'({bus_sel_n, ack}), 2);
        check(cfg_q == 8'h00 && !bus_cmd_oe, "R9", "cfg cleared", int'(cfg_q), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(bus_sel_n && !ack, "R9", "held in reset state", int'({bus_sel_n, ack}), 2);
        end
        req = 1'b0;
        cfg_write(8'h1F);
        check(cfg_q == 8'h00, "R9", "fields ignored while run is 0", int'(cfg_q), 0);
        cfg_write(cfgword(0, 0));
        check(cfg_q == 8'h30, "R9", "resume after run set", int'(cfg_q), 8'h30);
        bus_op(1'b0, 16'h0E0E, 16'h0000, 1, 1'b0);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R6", "all cycles acknowledged", expq.size(), 0);
        finish_run();
    end
endmodule